// File: doc/BRIEF.md
# Converter Calibration Sequencer

This block is the digital control heart of a sigma-delta converter's calibration. Software or a host controller writes a 3-bit mode field. Four of its codes start a calibration step. A step measures either the zero-scale (offset) point or the full-scale (gain) point, using either the converter's internal references or a level that the surrounding system drives onto the input. The sequencer times each step in output-rate periods. At the end of the step it stores the measurement in the matching coefficient register and clears the mode field. It then runs a follow-on conversion and flags fresh data through an active-low ready signal.

Internal-reference steps finish with three conversion periods. System-level steps finish with a single conversion on the same input level. Internal-reference steps therefore take six output periods from command to ready, and system steps take four. A gain step depends on an offset coefficient already being held. If none is held, the sequencer refuses the command and raises a sticky error flag. Each step leaves the other coefficient untouched, so offset and gain can be trimmed separately. When no calibration is running and the mode field reads zero, every output-rate tick loads a new conversion word.

The measurement comes from a behavioural modulator stub. The analog front end, the filter and the slope arithmetic lie outside this block.

Top module: `cal_seq_ctrl`

## Requirements
- R1: Mode codes (bit 2 down to bit 0) 3'b010 and 3'b011 start a system offset step and a system gain step. Codes 3'b110 and 3'b111 start an internal-reference offset step and an internal-reference gain step. Bit 1 set marks a calibration code, bit 0 set selects gain, and bit 2 set selects the internal reference. An accepted code reads back on `mode_rd` while its step runs.
- R2: A calibration step ends on the third `rate_tick` after the command. On that edge the selected coefficient captures `meas_in` and `mode_rd` returns to 3'b000. Before that edge, `mode_rd` still holds the code and the coefficient is unchanged.
- R3: After an accepted calibration command, `drdy_n` rises on the first `mod_tick` edge that follows the command edge. It does not fall again until the follow-on conversion word is loaded.
- R4: For an internal-reference step, `drdy_n` falls and `data_out` takes `meas_in` on the sixth `rate_tick` after the command, and not before.
- R5: For a system step, `drdy_n` falls and `data_out` takes `meas_in` on the fourth `rate_tick` after the command, and not before.
- R6: A gain command that arrives while `zs_valid` is low is refused. `mode_rd` reads 3'b000, both coefficients are unchanged and `cal_err` is set. Only reset clears `cal_err`.
- R7: An offset step leaves `fs_coef` unchanged, and a gain step leaves `zs_coef` unchanged.
- R8: `zs_valid` is cleared by reset and set when any offset step completes. After that, only reset clears it.
- R9: A mode write that arrives while a calibration step is running (before `mode_rd` has returned to 3'b000) is ignored.
- R10: While no calibration is running and `mode_rd` reads 3'b000, each `rate_tick` loads `meas_in` into `data_out` and drives `drdy_n` low.
- R11: After reset, `mode_rd` is 3'b000, `drdy_n` is 1, `data_out`, `zs_coef` and `fs_coef` are 0, and `zs_valid` and `cal_err` are 0.
- R12: A code with bit 1 clear other than 3'b000 (for example 3'b001 or 3'b100) is stored in `mode_rd` and starts nothing. While such a code is held, `rate_tick` changes neither `data_out` nor `drdy_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 3 | Mode code to write |
| mod_tick | input | 1 | One-cycle pulse per modulator cycle |
| rate_tick | input | 1 | One-cycle pulse per output-rate period |
| meas_in | input | DW | Measurement word from the modulator stub |
| mode_rd | output | 3 | Current mode field |
| drdy_n | output | 1 | Data-ready, active low |
| data_out | output | DW | Latest conversion word |
| zs_coef | output | DW | Zero-scale (offset) coefficient |
| fs_coef | output | DW | Full-scale (gain) coefficient |
| zs_valid | output | 1 | A zero-scale coefficient is held |
| cal_err | output | 1 | Sticky flag: a gain step was refused |

## Verification
The bench builds the block with DW at 16 and the period counts at their defaults of 3, 3 and 1. Every captured level and conversion word is therefore a distinct random 16-bit value that a single compare can attribute to the right edge. A modulator tick every 4 clocks and a rate tick every 32 clocks leave the ready-rise window and each of the six or four period boundaries far enough apart to sample on both sides. The bench issues a refused gain command before any offset step exists, a write in the middle of a step, and stored non-calibration codes, then random mixes of the four calibration codes.

// File: rtl/cal_seq_pkg.sv
`timescale 1ns/1ps
package cal_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAL  = 2'd1,
    ST_CONV = 2'd2
  } cal_state_e;

  typedef struct packed {
    logic is_cal;
    logic is_fs;
    logic is_self;
  } cal_cmd_t;

  localparam logic [2:0] MODE_NORMAL = 3'b000;

  // bit1: calibration code, bit0: gain point, bit2: internal reference
  function automatic cal_cmd_t decode_mode(input logic [2:0] code);
    cal_cmd_t c;
    c.is_cal  = code[1];
    c.is_fs   = code[0];
    c.is_self = code[2];
    return c;
  endfunction

endpackage

// File: rtl/cal_rst_sync.sv
`timescale 1ns/1ps
module cal_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/cal_period_timer.sv
`timescale 1ns/1ps
module cal_period_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick,
  input  logic [CW-1:0] target,
  output logic          last
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    last  = tick && (cnt_q == target - CW'(1));
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (last) cnt_d = '0;
    else if (tick) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cal_drdy_ctrl.sv
`timescale 1ns/1ps
module cal_drdy_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic word_ready,
  input  logic mod_tick,
  output logic drdy_n
);
  logic pend_q, pend_d;
  logic rdy_q, rdy_d;

  always_comb begin
    pend_d = pend_q;
    rdy_d  = rdy_q;
    if (word_ready) begin
      rdy_d  = 1'b0;
      pend_d = 1'b0;
    end else if (pend_q && mod_tick) begin
      rdy_d  = 1'b1;
      pend_d = 1'b0;
    end
    if (arm) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rdy_q  <= 1'b1;
    end else begin
      pend_q <= pend_d;
      rdy_q  <= rdy_d;
    end
  end

  assign drdy_n = rdy_q;
endmodule

// File: rtl/cal_coef_bank.sv
`timescale 1ns/1ps
module cal_coef_bank #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_zs,
  input  logic          cap_fs,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] zs_coef,
  output logic [DW-1:0] fs_coef,
  output logic          zs_valid
);
  localparam int NSLOT = 2;

  logic [NSLOT-1:0] cap;
  logic             valid_q;

  assign cap = {cap_fs, cap_zs};

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (cap[i]) q <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      valid_q <= 1'b0;
    else if (cap_zs) valid_q <= 1'b1;
  end

  assign zs_coef  = g_slot[0].q;
  assign fs_coef  = g_slot[1].q;
  assign zs_valid = valid_q;
endmodule

// File: rtl/cal_seq_ctrl.sv
`timescale 1ns/1ps
module cal_seq_ctrl
  import cal_seq_pkg::*;
#(
  parameter int DW                = 24,
  parameter int CAL_PERIODS       = 3,
  parameter int SELF_CONV_PERIODS = 3,
  parameter int SYS_CONV_PERIODS  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  logic [2:0]    mode_wdata,
  input  logic          mod_tick,
  input  logic          rate_tick,
  input  logic [DW-1:0] meas_in,
  output logic [2:0]    mode_rd,
  output logic          drdy_n,
  output logic [DW-1:0] data_out,
  output logic [DW-1:0] zs_coef,
  output logic [DW-1:0] fs_coef,
  output logic          zs_valid,
  output logic          cal_err
);
  localparam int MAX_A = (CAL_PERIODS > SELF_CONV_PERIODS) ? CAL_PERIODS : SELF_CONV_PERIODS;
  localparam int MAX_P = (MAX_A > SYS_CONV_PERIODS) ? MAX_A : SYS_CONV_PERIODS;
  localparam int CW    = $clog2(MAX_P + 1);

  logic       rst_i_n;
  cal_state_e state_q, state_d;
  logic [2:0] mode_q, mode_d;
  logic       self_q, self_d;
  logic       fs_q, fs_d;
  logic       err_q, err_d;
  logic [DW-1:0] data_q;

  cal_cmd_t   cmd;
  logic       accept, refuse, start, plain;
  logic       tmr_last, tmr_tick;
  logic       cal_done, conv_done, norm_conv, word_ready;
  logic       cap_zs, cap_fs;
  logic [CW-1:0] tgt;

  cal_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // command qualification and phase events
  always_comb begin
    cmd        = decode_mode(mode_wdata);
    accept     = mode_wr && (state_q != ST_CAL);
    refuse     = accept && cmd.is_cal && cmd.is_fs && !zs_valid;
    start      = accept && cmd.is_cal && !refuse;
    plain      = accept && !cmd.is_cal;
    cal_done   = (state_q == ST_CAL) && tmr_last;
    conv_done  = (state_q == ST_CONV) && tmr_last && !start;
    norm_conv  = (state_q == ST_IDLE) && (mode_q == MODE_NORMAL) && rate_tick && !accept;
    word_ready = conv_done || norm_conv;
    cap_zs     = cal_done && !fs_q;
    cap_fs     = cal_done && fs_q;
    tmr_tick   = rate_tick && (state_q != ST_IDLE);
    if (state_q == ST_CAL) tgt = CW'(CAL_PERIODS);
    else if (self_q)       tgt = CW'(SELF_CONV_PERIODS);
    else                   tgt = CW'(SYS_CONV_PERIODS);
  end

  // next state
  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    self_d  = self_q;
    fs_d    = fs_q;
    err_d   = err_q;
    if (start) begin
      state_d = ST_CAL;
      mode_d  = mode_wdata;
      self_d  = cmd.is_self;
      fs_d    = cmd.is_fs;
    end else begin
      if (cal_done) begin
        state_d = ST_CONV;
        mode_d  = MODE_NORMAL;
      end else if (conv_done) begin
        state_d = ST_IDLE;
      end
      if (plain) mode_d = mode_wdata;
      if (refuse) begin
        mode_d = MODE_NORMAL;
        err_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_NORMAL;
      self_q  <= 1'b0;
      fs_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      self_q  <= self_d;
      fs_q    <= fs_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)        data_q <= '0;
    else if (word_ready) data_q <= meas_in;
  end

  cal_period_timer #(.CW(CW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .clear  (start),
    .tick   (tmr_tick),
    .target (tgt),
    .last   (tmr_last)
  );

  cal_drdy_ctrl u_rdy (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .arm        (start),
    .word_ready (word_ready),
    .mod_tick   (mod_tick),
    .drdy_n     (drdy_n)
  );

  cal_coef_bank #(.DW(DW)) u_coef (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .cap_zs   (cap_zs),
    .cap_fs   (cap_fs),
    .din      (meas_in),
    .zs_coef  (zs_coef),
    .fs_coef  (fs_coef),
    .zs_valid (zs_valid)
  );

  assign mode_rd  = mode_q;
  assign data_out = data_q;
  assign cal_err  = err_q;
endmodule

// File: rtl/cal_seq_chk.sv
`timescale 1ns/1ps
module cal_seq_chk
  import cal_seq_pkg::*;
#(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_wr,
  input logic [2:0]    mode_wdata,
  input logic          mod_tick,
  input logic [2:0]    mode_rd,
  input logic          drdy_n,
  input logic [DW-1:0] zs_coef,
  input logic [DW-1:0] fs_coef,
  input logic          zs_valid,
  input logic          cal_err,
  input cal_state_e    state,
  input logic          fs_q
);
  // R6: gain command without offset coefficient is refused
  p_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_wdata[1] && mode_wdata[0] && !zs_valid && state != ST_CAL)
    |=> (cal_err && mode_rd == 3'b000 && $stable(fs_coef) && $stable(zs_coef)));

  // R6: error flag is sticky
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n) !$fell(cal_err));

  // R7: offset step keeps gain coefficient, gain step keeps offset coefficient
  p_zs_keeps_fs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAL && !fs_q) |=> $stable(fs_coef));
  p_fs_keeps_zs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAL && fs_q) |=> $stable(zs_coef));

  // R9: writes during a running step do not change the mode field
  p_busy_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAL && mode_wr) |=> (mode_rd == $past(mode_rd) || mode_rd == 3'b000));

  // R3: ready stays inactive through a step and rises only on a modulator tick
  p_cal_drdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAL && drdy_n) |=> drdy_n);
  p_drdy_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_n) |-> $past(mod_tick));

  // R2: leaving the step clears the mode field
  p_mode_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV && $past(state) == ST_CAL) |-> mode_rd == 3'b000);

  // R8: offset-valid flag never drops outside reset
  p_valid_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n) !$fell(zs_valid));
endmodule

bind cal_seq_ctrl cal_seq_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_i_n),
  .mode_wr    (mode_wr),
  .mode_wdata (mode_wdata),
  .mod_tick   (mod_tick),
  .mode_rd    (mode_rd),
  .drdy_n     (drdy_n),
  .zs_coef    (zs_coef),
  .fs_coef    (fs_coef),
  .zs_valid   (zs_valid),
  .cal_err    (cal_err),
  .state      (state_q),
  .fs_q       (fs_q)
);

// File: tb/sim_cal_seq_ctrl.sv
`timescale 1ns/1ps
module sim_cal_seq_ctrl;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode_wr;
  logic [2:0]    mode_wdata;
  logic          mod_tick, rate_tick;
  logic [DW-1:0] meas_in;
  logic [2:0]    mode_rd;
  logic          drdy_n;
  logic [DW-1:0] data_out, zs_coef, fs_coef;
  logic          zs_valid, cal_err;

  logic [4:0] tcnt = '0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic          m_valid;
  logic [DW-1:0] m_zs, m_fs;

  always #2.5 clk = ~clk;

  always @(posedge clk) tcnt <= tcnt + 5'd1;
  assign rate_tick = (tcnt == 5'd31);
  assign mod_tick  = (tcnt[1:0] == 2'b00);

  cal_seq_ctrl #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .mod_tick(mod_tick), .rate_tick(rate_tick), .meas_in(meas_in),
    .mode_rd(mode_rd), .drdy_n(drdy_n), .data_out(data_out),
    .zs_coef(zs_coef), .fs_coef(fs_coef), .zs_valid(zs_valid), .cal_err(cal_err)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int conv_periods(input logic [2:0] code);
    return code[2] ? 3 : 1;
  endfunction

  task automatic align();
    @(negedge clk);
    while (tcnt != 5'd8) @(negedge clk);
  endtask

  task automatic write_mode(input logic [2:0] code);
    align();
    mode_wr    = 1'b1;
    mode_wdata = code;
    @(negedge clk);
    mode_wr    = 1'b0;
  endtask

  task automatic to_rate();
    while (!rate_tick) @(negedge clk);
  endtask

  task automatic pass_rate(input int n);
    for (int k = 0; k < n; k++) begin
      to_rate();
      @(negedge clk);
    end
  endtask

  task automatic run_cal(input logic [2:0] code, input logic [DW-1:0] cal_lvl,
                         input logic [DW-1:0] conv_lvl, input bit poke);
    int done_ticks;
    string rq;
    rq = code[2] ? "R4" : "R5";
    meas_in = cal_lvl;
    write_mode(code);
    if (code[0] && !m_valid) begin
      check("R6", "refused mode", 32'(mode_rd), 32'(3'b000));
      check("R6", "error flag", 32'(cal_err), 32'd1);
      check("R6", "zs kept", 32'(zs_coef), 32'(m_zs));
      check("R6", "fs kept", 32'(fs_coef), 32'(m_fs));
      return;
    end
    check("R1", "mode readback", 32'(mode_rd), 32'(code));
    repeat (4) @(negedge clk);
    check("R3", "drdy raised", 32'(drdy_n), 32'd1);
    done_ticks = 0;
    if (poke) begin
      write_mode(3'b001);
      done_ticks = 1;
      check("R9", "write ignored", 32'(mode_rd), 32'(code));
    end
    pass_rate(2 - done_ticks);
    to_rate();
    check("R2", "mode before end", 32'(mode_rd), 32'(code));
    check("R2", "coef before end", 32'(code[0] ? fs_coef : zs_coef),
          32'(code[0] ? m_fs : m_zs));
    check("R3", "drdy held", 32'(drdy_n), 32'd1);
    @(negedge clk);
    check("R2", "mode cleared", 32'(mode_rd), 32'(3'b000));
    if (code[0]) begin
      check("R2", "fs captured", 32'(fs_coef), 32'(cal_lvl));
      check("R7", "zs untouched", 32'(zs_coef), 32'(m_zs));
      m_fs = cal_lvl;
    end else begin
      check("R2", "zs captured", 32'(zs_coef), 32'(cal_lvl));
      check("R7", "fs untouched", 32'(fs_coef), 32'(m_fs));
      check("R8", "zs valid", 32'(zs_valid), 32'd1);
      m_zs = cal_lvl;
      m_valid = 1'b1;
    end
    meas_in = conv_lvl;
    pass_rate(conv_periods(code) - 1);
    to_rate();
    check(rq, "drdy before word", 32'(drdy_n), 32'd1);
    @(negedge clk);
    check(rq, "drdy low", 32'(drdy_n), 32'd0);
    check(rq, "data word", 32'(data_out), 32'(conv_lvl));
  endtask

  task automatic run_plain(input logic [2:0] code);
    logic [DW-1:0] d0, lvl;
    logic dr0;
    meas_in = DW'($urandom);
    write_mode(code);
    check("R12", "plain readback", 32'(mode_rd), 32'(code));
    d0  = data_out;
    dr0 = drdy_n;
    meas_in = DW'($urandom);
    pass_rate(1);
    check("R12", "data held", 32'(data_out), 32'(d0));
    check("R12", "drdy held", 32'(drdy_n), 32'(dr0));
    write_mode(3'b000);
    lvl = DW'($urandom);
    meas_in = lvl;
    pass_rate(1);
    check("R10", "normal data", 32'(data_out), 32'(lvl));
    check("R10", "normal drdy", 32'(drdy_n), 32'd0);
  endtask

  initial begin
    logic [2:0] code;
    void'($urandom(32'd2024));
    rst_n = 1'b0; mode_wr = 1'b0; mode_wdata = 3'b000; meas_in = '0;
    m_valid = 1'b0; m_zs = '0; m_fs = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R11", "mode", 32'(mode_rd), 32'd0);
    check("R11", "drdy", 32'(drdy_n), 32'd1);
    check("R11", "data", 32'(data_out), 32'd0);
    check("R11", "zs", 32'(zs_coef), 32'd0);
    check("R11", "fs", 32'(fs_coef), 32'd0);
    check("R11", "valid", 32'(zs_valid), 32'd0);
    check("R11", "err", 32'(cal_err), 32'd0);
    // R6 directed: gain steps before any offset step
    run_cal(3'b111, DW'($urandom), DW'($urandom), 1'b0);
    run_cal(3'b011, DW'($urandom), DW'($urandom), 1'b0);
    run_plain(3'b100);
    run_cal(3'b010, DW'($urandom), DW'($urandom), 1'b1);
    run_cal(3'b011, DW'($urandom), DW'($urandom), 1'b0);
    run_cal(3'b110, DW'($urandom), DW'($urandom), 1'b0);
    run_cal(3'b111, DW'($urandom), DW'($urandom), 1'b1);
    run_plain(3'b001);
    for (int i = 0; i < 16; i++) begin
      case ($urandom % 6)
        0: code = 3'b010;
        1: code = 3'b011;
        2: code = 3'b110;
        3: code = 3'b111;
        4: code = 3'b100;
        default: code = 3'b001;
      endcase
      if (code[1]) run_cal(code, DW'($urandom), DW'($urandom), ($urandom % 4) == 0);
      else         run_plain(code);
    end
    check("R6", "err sticky", 32'(cal_err), 32'd1);
    check("R8", "valid sticky", 32'(zs_valid), 32'd1);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule